// File: doc/BRIEF.md
# Serial Byte Receiver with Parity Check

This block turns an asynchronous serial line back into bytes. The line idles high. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. Every bit lasts `divisor + 1` clock cycles. The divisor is the same value the matching transmitter uses, so both ends run at the same baud rate.

The incoming line first passes through a two-flop synchroniser. A falling edge on the synchronised line starts a frame. The start bit is checked again half a bit later, so a short low glitch does not start a frame. After that the block samples each bit near the centre of its bit period.

The 3-bit parity field selects one of five modes: none, odd, even, mark (parity bit always 1) or space (parity bit always 0). When the received parity bit does not match the selected mode, `parity_err` pulses. That pulse can drive an interrupt.

Each completed byte is offered on a valid/ready output. Back-pressure rules:
- `out_valid` stays high and `out_data` stays unchanged until `out_ready` accepts the byte.
- The line cannot be paused. If another frame completes while a byte is still waiting, the new byte replaces the waiting one.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, `out_valid` and `parity_err` are low.
- R2: A frame is a low start bit, 8 data bits (least significant first) and a high stop bit. Each bit lasts `divisor + 1` clocks. A good frame presents the byte on `out_data` with `out_valid` high.
- R3: `parity_mode` bit 0 enables the parity bit. Bit 2 selects a fixed parity bit, and bit 1 chooses its kind. The encodings are:
  - 3'b001: odd, so the data plus the parity bit hold an odd number of ones.
  - 3'b011: even.
  - 3'b101: mark, parity bit 1.
  - 3'b111: space, parity bit 0.
- R4: On a parity mismatch, the byte is still delivered. `parity_err` is high for exactly one cycle, and that cycle is the one in which the byte's `out_valid` goes high.
- R5: When `parity_mode` bit 0 is 0, the frame has no parity bit, and `parity_err` never asserts.
- R6: If the stop bit is sampled low, the frame is discarded. No `out_valid` and no `parity_err` are raised for it.
- R7: While `rx_en` is 0, no frame is received. Dropping `rx_en` in the middle of a frame aborts that frame.
- R8: The start bit is confirmed at its mid-point. A low pulse shorter than half a bit starts no frame.
- R9: `out_valid` holds until `out_ready` is high, and `out_data` stays stable while the byte waits. A newer frame that completes while a byte waits overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| divisor | input | 16 | Bit period minus one, in clocks |
| parity_mode | input | 3 | Parity selection (see R3) |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| out_valid | output | 1 | Received byte is available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Received byte |
| parity_err | output | 1 | One-cycle pulse on a parity mismatch |

## Verification
The bench runs each of the five parity modes, both with the correct parity bit and with a flipped one. A design that inverted odd and even, or mixed up mark and space, would flag good frames as errors and miss the bad ones.

Further tests send:
- a frame with a low stop bit, which a careless design would still deliver;
- a frame with receive enable off, and a frame where enable drops mid-frame, which a careless design would still deliver;
- a start glitch shorter than half a bit, which a design without mid-point confirmation would treat as a frame and use to decode garbage;
- a frame held under back-pressure and then overtaken by a second frame, which exposes a valid that drops early, data that changes while waiting, or a lost update.

Frames at two different divisors check that the bit period tracks `divisor + 1`.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/srx_parity.sv
module srx_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [2:0]   mode,
  output logic         enabled,
  output logic         expected
);
  always_comb begin
    enabled = mode[0];
    if (mode[2])      expected = ~mode[1];
    else if (mode[1]) expected = ^data;
    else              expected = ~^data;
  end
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import srx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic [DIV_W-1:0]     divisor,
  input  logic [2:0]           parity_mode,
  input  logic                 rx_line,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 parity_err
);
  localparam int IDX_W = $clog2(DATA_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  srx_state_e           state;
  logic                 rx_s, rx_prev, fall;
  logic                 load, tick;
  logic [DIV_W-1:0]     load_val;
  logic [DATA_BITS-1:0] shreg;
  logic [IDX_W-1:0]     bit_idx;
  logic                 par_on, par_exp, par_bad;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  srx_bit_timer #(.CW(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .tick(tick)
  );

  srx_parity #(.W(DATA_BITS)) u_par (
    .data(shreg), .mode(parity_mode), .enabled(par_on), .expected(par_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= rx_s;
  end

  assign fall = rx_prev & ~rx_s;

  always_comb begin
    load     = 1'b0;
    load_val = divisor;
    case (state)
      S_IDLE: if (rx_en && fall) begin
        load     = 1'b1;
        load_val = divisor >> 1;
      end
      S_START, S_DATA, S_PAR: load = tick;
      default: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      shreg      <= '0;
      bit_idx    <= '0;
      par_bad    <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      parity_err <= 1'b0;
    end else begin
      parity_err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!rx_en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            bit_idx <= '0;
            par_bad <= 1'b0;
            if (fall) state <= S_START;
          end
          S_START: if (tick) state <= rx_s ? S_IDLE : S_DATA;
          S_DATA: if (tick) begin
            shreg   <= {rx_s, shreg[DATA_BITS-1:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == LAST_IDX) state <= par_on ? S_PAR : S_STOP;
          end
          S_PAR: if (tick) begin
            par_bad <= (rx_s != par_exp);
            state   <= S_STOP;
          end
          S_STOP: if (tick) begin
            state <= S_IDLE;
            if (rx_s) begin
              out_valid  <= 1'b1;
              out_data   <= shreg;
              parity_err <= par_bad;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk
  import srx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_en,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DATA_BITS-1:0] out_data,
  input logic                 parity_err,
  input srx_state_e           state
);
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r9_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && state != S_STOP |=> $stable(out_data));

  a_r4_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> out_valid);

  a_r4_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> !parity_err);

  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state == S_IDLE);

  a_r6_valid_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state) == S_STOP);
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .parity_err(parity_err),
  .state(state)
);

// File: tb/serial_byte_rx_test.sv
module serial_byte_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {data, parity_mode, flip parity bit}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'hA5, 3'b000, 1'b0}, {8'h3C, 3'b010, 1'b1},
    {8'h01, 3'b001, 1'b0}, {8'h07, 3'b001, 1'b1},
    {8'h81, 3'b011, 1'b0}, {8'hFE, 3'b011, 1'b1},
    {8'h5A, 3'b101, 1'b0}, {8'h00, 3'b101, 1'b1},
    {8'hC3, 3'b111, 1'b0}, {8'hFF, 3'b111, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, rx_line = 1'b1, out_ready = 1'b1;
  logic [2:0] parity_mode = 3'b000;
  logic [15:0] divisor;
  logic out_valid, parity_err;
  logic [7:0] out_data;
  int divv = 9;
  int n_chk = 0, n_fail = 0, hs_cnt = 0, err_cnt = 0;
  logic [7:0] last_data = '0;
  logic last_err = 1'b0;

  assign divisor = 16'(divv);
  always #(CLK_PERIOD/2) clk = ~clk;

  serial_byte_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .divisor(divisor),
    .parity_mode(parity_mode), .rx_line(rx_line), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .parity_err(parity_err)
  );

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      hs_cnt++;
      last_data = out_data;
      last_err = parity_err;
    end
    if (parity_err) err_cnt++;
  end

  function automatic logic par_bit(input logic [7:0] d, input logic [2:0] m);
    int ones = $countones(d);
    if (m == 3'b101) return 1'b1;
    if (m == 3'b111) return 1'b0;
    if (m == 3'b011) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [2:0] m,
                            input logic flip, input logic stop_v, input int abort_at);
    @(negedge clk);
    parity_mode = m;
    rx_line = 1'b0;
    repeat (divv + 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      if (i == abort_at) begin
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        repeat (divv) @(negedge clk);
      end else begin
        repeat (divv + 1) @(negedge clk);
      end
    end
    if (m[0]) begin
      rx_line = par_bit(d, m) ^ flip;
      repeat (divv + 1) @(negedge clk);
    end
    rx_line = stop_v;
    repeat (divv + 1) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * (divv + 1)) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 err after reset", int'(parity_err), 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5: vector walk over all parity modes
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] d;
      logic [2:0] m;
      logic f;
      {d, m, f} = VEC[v];
      h0 = hs_cnt; e0 = err_cnt;
      send_frame(d, m, f, 1'b1, -1);
      check("R2 one byte delivered", hs_cnt - h0, 1);
      check("R2 data", int'(last_data), int'(d));
      check("R4 R5 err pulse count", err_cnt - e0, int'(f & m[0]));
      check("R4 err same cycle as valid", int'(last_err), int'(f & m[0]));
    end

    // R2: a different divisor
    divv = 15;
    h0 = hs_cnt;
    send_frame(8'h96, 3'b011, 1'b0, 1'b1, -1);
    check("R2 divisor 15 count", hs_cnt - h0, 1);
    check("R2 divisor 15 data", int'(last_data), 32'h96);
    divv = 9;

    // R6: low stop bit
    h0 = hs_cnt; e0 = err_cnt;
    send_frame(8'h6B, 3'b001, 1'b1, 1'b0, -1);
    check("R6 bad stop no valid", hs_cnt - h0, 0);
    check("R6 bad stop no err", err_cnt - e0, 0);

    // R7: disabled receiver
    rx_en = 1'b0;
    h0 = hs_cnt;
    send_frame(8'h12, 3'b000, 1'b0, 1'b1, -1);
    rx_en = 1'b1;
    check("R7 disabled no valid", hs_cnt - h0, 0);

    // R7: abort mid-frame
    h0 = hs_cnt;
    send_frame(8'hFF, 3'b000, 1'b0, 1'b1, 2);
    check("R7 abort no valid", hs_cnt - h0, 0);

    // R8: short start glitch
    h0 = hs_cnt;
    @(negedge clk); rx_line = 1'b0;
    repeat (2) @(negedge clk); rx_line = 1'b1;
    repeat (4 * (divv + 1)) @(negedge clk);
    check("R8 glitch no valid", hs_cnt - h0, 0);

    // R9: back-pressure and overwrite
    out_ready = 1'b0;
    h0 = hs_cnt;
    send_frame(8'h4D, 3'b000, 1'b0, 1'b1, -1);
    check("R9 valid held", int'(out_valid), 1);
    check("R9 data waiting", int'(out_data), 32'h4D);
    repeat (7) @(negedge clk);
    check("R9 still held", int'(out_valid), 1);
    check("R9 data stable", int'(out_data), 32'h4D);
    send_frame(8'hB2, 3'b000, 1'b0, 1'b1, -1);
    check("R9 overwritten data", int'(out_data), 32'hB2);
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 single handshake", hs_cnt - h0, 1);
    check("R9 handshake data", int'(last_data), 32'hB2);
    check("R9 valid dropped", int'(out_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule